// File: doc/BRIEF.md
# Byte-Bus DAC Word Writer

This block links an 8-bit processor write port to a 12-bit parallel multiplying DAC. That DAC has a level-sensitive input latch: the latch passes data while its select and write strobes are both low, and it keeps the last value once either strobe goes high. The processor builds each conversion code from two byte writes to two decoded addresses. A write to the high address places four bits in a staging register. A write to the low address supplies the remaining eight bits and starts a transfer to the converter.

When a low-byte write is accepted, the block forms the 12-bit word from the staged nibble and the new byte. It can remap that word for bipolar (two's-complement) data or to keep a zero code away from a converter wired as a gain element. It then runs the select and write strobes through setup, pulse and hold phases, each of which lasts a set number of clocks. During a transfer the block lowers `ready`. A low-byte write presented at that time is not taken: the host keeps it on the bus until `ready` returns. Nibble writes are accepted at any time and never move the strobes.

Top module: `dacwr_byte_bridge`

## Requirements
- R1: While reset is asserted and directly after it is released, `dac_data` is 000h, `dac_cs_n` and `dac_wr_n` are high, `ready` is high, and the staged nibble is zero. A low-byte write made after reset with no nibble write first therefore produces an upper nibble of 0.
- R2: A write with `bus_sel_hi`=1 only loads `bus_data[3:0]` into the staging register. Neither strobe goes low, `ready` stays high, and `dac_data` keeps its value.
- R3: A low-byte write (`bus_wr`=1, `bus_sel_hi`=0) is accepted at a clock edge where `ready` is high. From the next cycle, `dac_data` holds the mapped word, whose bits 11..8 come from the staged nibble and bits 7..0 from `bus_data`. From that same cycle `dac_cs_n` is low and `ready` is low.
- R4: After acceptance, `dac_cs_n` is low with `dac_wr_n` high for SETUP_CYC cycles. Next, both are low for PULSE_CYC cycles. Next, both are high together for HOLD_CYC cycles. `dac_wr_n` is never low while `dac_cs_n` is high.
- R5: `dac_data` does not change from the cycle after acceptance until `ready` returns high. `ready` returns high HOLD_CYC cycles after `dac_wr_n` rises.
- R6: A low-byte write presented while `ready` is low is not accepted and does not disturb `dac_data`. If the host keeps it on the bus, it is accepted at the first edge at which `ready` is high.
- R7: A nibble write made during a transfer updates the staging register but leaves the word being driven unchanged. The next accepted low byte uses the new nibble.
- R8: When `bipolar_en` is 1 at acceptance, bit 11 of the word is inverted and all other bits pass through unchanged (two's complement to offset binary).
- R9: When `clamp_en` is 1 at acceptance and the word after the bipolar step is 000h, the word 001h is driven instead. With `clamp_en` at 0, a code of 000h is driven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write request, held by the host until accepted |
| bus_sel_hi | input | 1 | Address decode: 1 selects the nibble staging register, 0 selects the low byte |
| bus_data | input | 8 | Bus write data; bits 3..0 are used for nibble writes |
| bipolar_en | input | 1 | Convert two's complement to offset binary by inverting bit 11 |
| clamp_en | input | 1 | Replace code 000h with 001h |
| ready | output | 1 | High when a low-byte write can be accepted |
| dac_data | output | 12 | Word driven to the DAC data pins, bit 11 is the MSB |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_wr_n | output | 1 | DAC write strobe, active low |

## Verification
A nibble write and a running strobe sequence can occur in the same cycle. A low-byte write held on the bus during a busy transfer also collides with the end of that sequence. The bench forces both cases: it issues a nibble write in the first setup cycle, and it places a pending low byte on the bus in the second cycle and leaves it there. It then checks in every cycle that the driven word and the strobes follow only the first transfer. The held byte must be accepted at the exact edge where `ready` returns, and its word must carry the nibble written in the middle of the first transfer.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SETUP = 2'd1,
      SEQ_PULSE = 2'd2,
      SEQ_HOLD  = 2'd3
   } seq_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/dacwr_stage.sv
module dacwr_stage #(
   parameter int NIB_W = 4,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BUS_W-1:0] din,
   output logic [NIB_W-1:0] nib_q
);

   if (NIB_W > BUS_W) begin : g_bad_width
      $error("dacwr_stage: NIB_W must not exceed BUS_W");
   end

   logic [BUS_W-1:0] din_unused;
   assign din_unused = din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         nib_q <= '0;
      else if (load)
         nib_q <= din_unused[NIB_W-1:0];
   end

endmodule

// File: rtl/dacwr_code_map.sv
module dacwr_code_map #(
   parameter int WORD_W      = 12,
   parameter bit HAS_BIPOLAR = 1'b1,
   parameter bit HAS_CLAMP   = 1'b1
) (
   input  logic [WORD_W-1:0] raw,
   input  logic              bipolar_en,
   input  logic              clamp_en,
   output logic [WORD_W-1:0] code
);

   localparam logic [WORD_W-1:0] ONE_LSB = WORD_W'(1);

   logic [WORD_W-1:0] bip_word;

   if (WORD_W < 2) begin : g_bad_width
      $error("dacwr_code_map: WORD_W must be at least 2");
   end

   if (HAS_BIPOLAR) begin : g_bipolar
      assign bip_word = {raw[WORD_W-1] ^ bipolar_en, raw[WORD_W-2:0]};
   end else begin : g_no_bipolar
      logic bip_unused;
      assign bip_unused = bipolar_en;
      assign bip_word   = raw;
   end

   if (HAS_CLAMP) begin : g_clamp
      assign code = (clamp_en && (bip_word == '0)) ? ONE_LSB : bip_word;
   end else begin : g_no_clamp
      logic clamp_unused;
      assign clamp_unused = clamp_en;
      assign code         = bip_word;
   end

endmodule

// File: rtl/dacwr_strobe_seq.sv
module dacwr_strobe_seq
   import dacwr_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3,
   parameter int HOLD_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic cs_n,
   output logic wr_n
);

   localparam int MAX_CYC = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(HOLD_CYC - 1);

   if (SETUP_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
      $error("dacwr_strobe_seq: every phase needs at least one cycle");
   end

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last;

   assign last = (cnt_q == '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (start) begin
               state_d = SEQ_SETUP;
               cnt_d   = SETUP_LOAD;
            end
         end
         SEQ_SETUP: begin
            if (last) begin
               state_d = SEQ_PULSE;
               cnt_d   = PULSE_LOAD;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         SEQ_PULSE: begin
            if (last) begin
               state_d = SEQ_HOLD;
               cnt_d   = HOLD_LOAD;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         SEQ_HOLD: begin
            if (last) begin
               state_d = SEQ_IDLE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy = (state_q != SEQ_IDLE);
   assign cs_n = (state_q == SEQ_IDLE) || (state_q == SEQ_HOLD);
   assign wr_n = (state_q != SEQ_PULSE);

endmodule

// File: rtl/dacwr_byte_bridge.sv
module dacwr_byte_bridge #(
   parameter int NIB_W       = 4,
   parameter int BUS_W       = 8,
   parameter int SETUP_CYC   = 2,
   parameter int PULSE_CYC   = 3,
   parameter int HOLD_CYC    = 2,
   parameter bit HAS_BIPOLAR = 1'b1,
   parameter bit HAS_CLAMP   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic                   bus_sel_hi,
   input  logic [BUS_W-1:0]       bus_data,
   input  logic                   bipolar_en,
   input  logic                   clamp_en,
   output logic                   ready,
   output logic [NIB_W+BUS_W-1:0] dac_data,
   output logic                   dac_cs_n,
   output logic                   dac_wr_n
);

   localparam int WORD_W = NIB_W + BUS_W;

   logic              load_hi;
   logic              accept_lo;
   logic              busy;
   logic [NIB_W-1:0]  nib_q;
   logic [WORD_W-1:0] mapped;
   logic [WORD_W-1:0] word_q;

   assign load_hi   = bus_wr && bus_sel_hi;
   assign accept_lo = bus_wr && !bus_sel_hi && !busy;

   dacwr_stage #(
      .NIB_W (NIB_W),
      .BUS_W (BUS_W)
   ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_hi),
      .din   (bus_data),
      .nib_q (nib_q)
   );

   dacwr_code_map #(
      .WORD_W      (WORD_W),
      .HAS_BIPOLAR (HAS_BIPOLAR),
      .HAS_CLAMP   (HAS_CLAMP)
   ) u_map (
      .raw        ({nib_q, bus_data}),
      .bipolar_en (bipolar_en),
      .clamp_en   (clamp_en),
      .code       (mapped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (accept_lo)
         word_q <= mapped;
   end

   dacwr_strobe_seq #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept_lo),
      .busy  (busy),
      .cs_n  (dac_cs_n),
      .wr_n  (dac_wr_n)
   );

   assign ready    = !busy;
   assign dac_data = word_q;

endmodule

// File: rtl/dacwr_byte_bridge_checker.sv
module dacwr_byte_bridge_checker #(
   parameter int WORD_W    = 12,
   parameter int BUS_W     = 8,
   parameter bit HAS_CLAMP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_sel_hi,
   input logic [BUS_W-1:0]  bus_data,
   input logic              clamp_en,
   input logic              ready,
   input logic [WORD_W-1:0] dac_data,
   input logic              dac_cs_n,
   input logic              dac_wr_n
);

   logic [BUS_W-1:0] data_unused;
   assign data_unused = bus_data;

   assert_nibble_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && bus_wr && bus_sel_hi) |=> (dac_cs_n && dac_wr_n && ready));

   assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && bus_wr && !bus_sel_hi) |=> (!dac_cs_n && dac_wr_n && !ready));

   assert_wr_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_wr_n |-> !dac_cs_n);

   assert_setup_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_wr_n) |-> $past(!dac_cs_n));

   assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(dac_data));

   assert_busy_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && bus_wr && !bus_sel_hi) |=> $stable(dac_data));

   if (HAS_CLAMP) begin : g_clamp_chk
      assert_no_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (ready && bus_wr && !bus_sel_hi && clamp_en) |=> (dac_data != '0));
   end else begin : g_no_clamp_chk
      logic clamp_unused;
      assign clamp_unused = clamp_en;
   end

endmodule

bind dacwr_byte_bridge dacwr_byte_bridge_checker #(
   .WORD_W    (NIB_W + BUS_W),
   .BUS_W     (BUS_W),
   .HAS_CLAMP (HAS_CLAMP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_sel_hi (bus_sel_hi),
   .bus_data   (bus_data),
   .clamp_en   (clamp_en),
   .ready      (ready),
   .dac_data   (dac_data),
   .dac_cs_n   (dac_cs_n),
   .dac_wr_n   (dac_wr_n)
);

// File: tb/dacwr_byte_bridge_bench.sv
module dacwr_byte_bridge_bench;

   localparam int S = 2;
   localparam int P = 3;
   localparam int H = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sel_hi = 1'b0;
   logic [7:0]  bus_data = 8'h00;
   logic        bipolar_en = 1'b0;
   logic        clamp_en = 1'b0;
   logic        ready;
   logic [11:0] dac_data;
   logic        dac_cs_n;
   logic        dac_wr_n;

   int tests = 0;
   int fails = 0;
   logic [3:0]  stage_m = 4'h0;
   logic [11:0] word_m  = 12'h000;

   always #10 clk = ~clk;

   dacwr_byte_bridge #(
      .NIB_W(4), .BUS_W(8), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
      .HAS_BIPOLAR(1'b1), .HAS_CLAMP(1'b1)
   ) u_dacwr_byte_bridge (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_hi(bus_sel_hi),
      .bus_data(bus_data), .bipolar_en(bipolar_en), .clamp_en(clamp_en),
      .ready(ready), .dac_data(dac_data), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n)
   );

   function automatic logic [11:0] exp_code(input logic [3:0] n, input logic [7:0] b,
                                            input logic bip, input logic clp);
      logic [11:0] w;
      w = {n, b};
      if (bip) w[11] = ~w[11];
      if (clp && w == 12'h000) w = 12'h001;
      return w;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic nib_write(input logic [3:0] n);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel_hi = 1'b1; bus_data = {4'hA, n};
      @(posedge clk);
      stage_m = n;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // host holds the low-byte write until an edge with ready high takes it
   task automatic wait_accept(input logic [7:0] b, input logic bip, input logic clp);
      logic r;
      bus_wr = 1'b1; bus_sel_hi = 1'b0; bus_data = b;
      bipolar_en = bip; clamp_en = clp;
      forever begin
         r = ready;
         @(posedge clk);
         if (r) break;
         @(negedge clk);
      end
      word_m = exp_code(stage_m, b, bip, clp);
      @(negedge clk);
   endtask

   task automatic run_seq(input string tag, input bit mid_en, input logic [3:0] mid_nib,
                          input bit next_en, input logic [7:0] next_byte);
      string dreq;
      dreq = next_en ? "R6" : (mid_en ? "R7" : "R5");
      check(tag, "accepted word", dac_data, word_m);
      check("R3", "ready low after accept", ready, 1'b0);
      for (int j = 0; j < S + P + H; j++) begin
         if (j == 0) begin
            if (mid_en) begin
               bus_wr = 1'b1; bus_sel_hi = 1'b1; bus_data = {4'h0, mid_nib};
            end else bus_wr = 1'b0;
         end
         if (j == 1) begin
            if (mid_en) stage_m = mid_nib;
            if (next_en) begin
               bus_wr = 1'b1; bus_sel_hi = 1'b0; bus_data = next_byte;
            end else bus_wr = 1'b0;
         end
         if (j < S)          check("R4", "setup strobes", {dac_cs_n, dac_wr_n}, 2'b01);
         else if (j < S + P) check("R4", "pulse strobes", {dac_cs_n, dac_wr_n}, 2'b00);
         else                check("R4", "hold strobes",  {dac_cs_n, dac_wr_n}, 2'b11);
         check(dreq, "word during transfer", dac_data, word_m);
         check("R5", "busy during transfer", ready, 1'b0);
         @(negedge clk);
      end
      check("R5", "ready after hold", ready, 1'b1);
      check("R5", "word after hold", dac_data, word_m);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "data in reset", dac_data, 12'h000);
      check("R1", "strobes in reset", {dac_cs_n, dac_wr_n}, 2'b11);
      check("R1", "ready in reset", ready, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "strobes after reset", {dac_cs_n, dac_wr_n}, 2'b11);
      check("R1", "ready after reset", ready, 1'b1);
      // R1: staged nibble cleared
      wait_accept(8'h5A, 1'b0, 1'b0);
      check("R1", "nibble zero after reset", dac_data, 12'h05A);
      run_seq("R3", 1'b0, 4'h0, 1'b0, 8'h00);

      // R2: nibble alone never strobes
      nib_write(4'hC);
      for (int k = 0; k < 3; k++) begin
         check("R2", "strobes idle", {dac_cs_n, dac_wr_n}, 2'b11);
         check("R2", "ready idle", ready, 1'b1);
         check("R2", "word unchanged", dac_data, 12'h05A);
         @(negedge clk);
      end
      wait_accept(8'h33, 1'b0, 1'b0);
      run_seq("R3", 1'b0, 4'h0, 1'b0, 8'h00);
      check("R3", "nibble plus byte", dac_data, 12'hC33);

      // R9 / R8 directed corners
      nib_write(4'h0);
      wait_accept(8'h00, 1'b0, 1'b0);
      run_seq("R9", 1'b0, 4'h0, 1'b0, 8'h00);
      check("R9", "zero passes unclamped", dac_data, 12'h000);
      wait_accept(8'h00, 1'b0, 1'b1);
      run_seq("R9", 1'b0, 4'h0, 1'b0, 8'h00);
      check("R9", "zero clamped", dac_data, 12'h001);
      nib_write(4'h8);
      wait_accept(8'h00, 1'b1, 1'b1);
      run_seq("R9", 1'b0, 4'h0, 1'b0, 8'h00);
      check("R9", "bipolar 800h clamped", dac_data, 12'h001);
      nib_write(4'h7);
      wait_accept(8'hFF, 1'b1, 1'b0);
      run_seq("R8", 1'b0, 4'h0, 1'b0, 8'h00);
      check("R8", "bipolar 7FFh", dac_data, 12'hFFF);
      nib_write(4'hF);
      wait_accept(8'hFF, 1'b1, 1'b1);
      run_seq("R8", 1'b0, 4'h0, 1'b0, 8'h00);
      check("R8", "bipolar FFFh", dac_data, 12'h7FF);

      // R6 / R7: nibble during transfer plus a held low byte
      nib_write(4'h2);
      wait_accept(8'h11, 1'b0, 1'b0);
      run_seq("R3", 1'b1, 4'h9, 1'b1, 8'h44);
      wait_accept(8'h44, 1'b0, 1'b0);
      check("R7", "held write uses new nibble", dac_data, 12'h944);
      run_seq("R6", 1'b0, 4'h0, 1'b0, 8'h00);

      // random mix
      for (int i = 0; i < 60; i++) begin
         logic [3:0] n;
         logic [7:0] b;
         logic bip, clp;
         n = 4'($urandom); b = 8'($urandom);
         bip = 1'($urandom); clp = 1'($urandom);
         if (i % 7 == 0) begin n = 4'h0; b = 8'h00; end
         if (1'($urandom)) nib_write(n);
         wait_accept(b, bip, clp);
         run_seq(bip ? "R8" : (clp ? "R9" : "R3"), 1'($urandom), 4'($urandom), 1'b0, 8'h00);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule